// File: doc/BRIEF.md
# DMA Channel Address Register Bank

This block keeps the transfer addresses for an eight-channel DMA controller of the older kind. Each channel owns two 16-bit values: a base address, kept for reloads, and a current address, which moves as data is transferred. Software reaches both through a narrow 8-bit register port. A byte pointer flip-flop picks which half of the 16-bit value the next access touches. There is one pointer for each controller half. Channels 0 to 3 share one pointer and channels 4 to 7 share the other.

The DMA engine pulses a transfer strobe and names the active channel. The block then presents that channel's bus address and, on the clock edge, moves the current address one step up or down. If auto-initialize is set for the channel and the transfer hits terminal count, the current address is restored from the base instead. The upper four channels move 16-bit words, so their bus address is the stored value shifted left by one place. Channel 4 serves as the cascade link between the two halves and never produces a transfer address. The direction, auto-initialize and terminal-count settings arrive as per-channel inputs from the mode logic.

Top module: `dmaAddrRegs`

## Requirements
- R1: A register write stores `wrData` into the byte of the selected channel that the pointer names (pointer 0 = bits 7:0, pointer 1 = bits 15:8). It writes the same byte of both the base and the current address. The other byte is left unchanged.
- R2: During a register read, `rdData` shows the pointed-to byte of the channel's current address, never its base address.
- R3: A transfer strobe on a non-cascade channel, without a reload, adds one to the current address when `decMode` for that channel is 0 and subtracts one when it is 1. Both directions wrap modulo 2^16.
- R4: A transfer on a channel with both `autoInit` and `termCnt` set loads the current address from the base address. With terminal count set and auto-initialize clear, the channel steps as in R3.
- R5: `xferAddr` is combinational from the current address of `xferCh`. For channels 0 to 3 it is {0, current}. For channels 5 to 7 it is {current, 0}, so bit 15 appears at bit 16 and bit 0 is 0.
- R6: Each register access, read or write, toggles the pointer of the accessed half. Channels 0 to 3 share one pointer and channels 4 to 7 share the other. An access in one half leaves the other half's pointer alone.
- R7: `clrPtr[h]` or `masterClr[h]` sets the pointer of half h (h = channel bit 2) to the low byte on the next edge. This takes priority over a toggle from an access in the same cycle, though that access still uses the old pointer.
- R8: Channel 4 is the cascade channel. A transfer strobe on it changes no address, and `xferAddr` reads 0 while `xferCh` is 4.
- R9: When a register write and a transfer name the same channel in one cycle, the write takes effect and that transfer's step or reload is dropped.
- R10: Reset clears both byte pointers to the low byte. The address contents stay undefined until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regCs | input | 1 | Register access strobe, one byte per cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regCh | input | 3 | Channel addressed by the register access |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte (combinational) |
| clrPtr | input | 2 | Clear-byte-pointer command, one bit per half |
| masterClr | input | 2 | Master-clear command, one bit per half |
| xferStb | input | 1 | Transfer completed this cycle |
| xferCh | input | 3 | Channel being serviced |
| decMode | input | 8 | Per-channel count-down select |
| autoInit | input | 8 | Per-channel auto-initialize enable |
| termCnt | input | 8 | Per-channel terminal count reached |
| xferAddr | output | 17 | Bus address of the serviced channel |

## Verification
The bench builds the block with its default package values: eight channels split into two halves, 16-bit addresses, 8-bit data and channel 4 as the cascade link. These values bring the word-shift path, the cascade suppression and the two independent byte pointers within reach together. Addresses near 0x0000 and 0xFFFE, and word values with bit 15 set, exercise both wrap directions and the carry into output bit 16. A long randomized phase mixes accesses, clears and transfers across both halves.

// File: rtl/dmaAddrPkg.sv
`timescale 1ns/1ps
package dmaAddrPkg;
  parameter int NUM_CH     = 8;
  parameter int ADDR_W     = 16;
  parameter int DATA_W     = 8;
  parameter int CASCADE_CH = 4;

  localparam int CH_W     = $clog2(NUM_CH);
  localparam int HALF_CH  = NUM_CH / 2;
  localparam int NUM_HALF = 2;
  localparam int OUT_W    = ADDR_W + 1;

  typedef logic [NUM_CH-1:0] chVec_t;

  // strobes from control to datapath
  typedef struct packed {
    chVec_t wrLo;
    chVec_t wrHi;
    chVec_t step;
    chVec_t down;
    chVec_t reload;
    logic   rdHi;
  } addrStb_t;
endpackage

// File: rtl/dmaAddrCtrl.sv
`timescale 1ns/1ps
module dmaAddrCtrl
  import dmaAddrPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regCs,
  input  logic                regWr,
  input  logic [CH_W-1:0]     regCh,
  input  logic [NUM_HALF-1:0] clrPtr,
  input  logic [NUM_HALF-1:0] masterClr,
  input  logic                xferStb,
  input  logic [CH_W-1:0]     xferCh,
  input  chVec_t              decMode,
  input  chVec_t              autoInit,
  input  chVec_t              termCnt,
  output addrStb_t            stb,
  output logic [NUM_HALF-1:0] bytePtr
);
  logic accHalf;
  logic curPtr;
  logic wrAny;

  assign accHalf = regCh[CH_W-1];
  assign curPtr  = bytePtr[accHalf];
  assign wrAny   = regCs && regWr;

  // one byte pointer flip-flop per controller half
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_ptr
    logic accHere;
    assign accHere = regCs && (accHalf == 1'(h));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytePtr[h] <= 1'b0;
      end else if (clrPtr[h] || masterClr[h]) begin
        bytePtr[h] <= 1'b0;
      end else if (accHere) begin
        bytePtr[h] <= ~bytePtr[h];
      end
    end
  end

  always_comb begin
    stb = '0;
    stb.rdHi = curPtr;
    stb.down = decMode;
    for (int c = 0; c < NUM_CH; c++) begin
      logic regHit;
      logic xHit;
      regHit = wrAny && (regCh == CH_W'(c));
      xHit   = xferStb && (xferCh == CH_W'(c)) && (c != CASCADE_CH) && !regHit;
      stb.wrLo[c]   = regHit && !curPtr;
      stb.wrHi[c]   = regHit && curPtr;
      stb.reload[c] = xHit && autoInit[c] && termCnt[c];
      stb.step[c]   = xHit && !(autoInit[c] && termCnt[c]);
    end
  end
endmodule

// File: rtl/dmaAddrPath.sv
`timescale 1ns/1ps
module dmaAddrPath
  import dmaAddrPkg::*;
(
  input  logic                           clk,
  input  addrStb_t                       stb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [CH_W-1:0]                regCh,
  input  logic [CH_W-1:0]                xferCh,
  output logic [DATA_W-1:0]              rdData,
  output logic [OUT_W-1:0]               xferAddr,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  curAddr,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  baseAddr
);
  logic [NUM_CH-1:0][OUT_W-1:0] fmtAddr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // address contents have no reset value
    always_ff @(posedge clk) begin
      if (stb.wrLo[c]) begin
        baseAddr[c][DATA_W-1:0] <= wrData;
        curAddr[c][DATA_W-1:0]  <= wrData;
      end else if (stb.wrHi[c]) begin
        baseAddr[c][ADDR_W-1:DATA_W] <= wrData;
        curAddr[c][ADDR_W-1:DATA_W]  <= wrData;
      end else if (stb.reload[c]) begin
        curAddr[c] <= baseAddr[c];
      end else if (stb.step[c]) begin
        curAddr[c] <= stb.down[c] ? curAddr[c] - ADDR_W'(1) : curAddr[c] + ADDR_W'(1);
      end
    end

    if (c == CASCADE_CH) begin : g_casc
      assign fmtAddr[c] = '0;
    end else if (c >= HALF_CH) begin : g_word
      assign fmtAddr[c] = {curAddr[c], 1'b0};
    end else begin : g_byte
      assign fmtAddr[c] = {1'b0, curAddr[c]};
    end
  end

  assign rdData   = stb.rdHi ? curAddr[regCh][ADDR_W-1:DATA_W] : curAddr[regCh][DATA_W-1:0];
  assign xferAddr = fmtAddr[xferCh];
endmodule

// File: rtl/dmaAddrRegs.sv
`timescale 1ns/1ps
module dmaAddrRegs
  import dmaAddrPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regCs,
  input  logic                regWr,
  input  logic [CH_W-1:0]     regCh,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_HALF-1:0] clrPtr,
  input  logic [NUM_HALF-1:0] masterClr,
  input  logic                xferStb,
  input  logic [CH_W-1:0]     xferCh,
  input  logic [NUM_CH-1:0]   decMode,
  input  logic [NUM_CH-1:0]   autoInit,
  input  logic [NUM_CH-1:0]   termCnt,
  output logic [OUT_W-1:0]    xferAddr
);
  addrStb_t                      stb;
  logic [NUM_HALF-1:0]           bytePtr;
  logic [NUM_CH-1:0][ADDR_W-1:0] curAddr;
  logic [NUM_CH-1:0][ADDR_W-1:0] baseAddr;

  dmaAddrCtrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .regCs(regCs), .regWr(regWr), .regCh(regCh),
    .clrPtr(clrPtr), .masterClr(masterClr), .xferStb(xferStb), .xferCh(xferCh),
    .decMode(decMode), .autoInit(autoInit), .termCnt(termCnt),
    .stb(stb), .bytePtr(bytePtr)
  );

  dmaAddrPath i_path (
    .clk(clk), .stb(stb), .wrData(wrData), .regCh(regCh), .xferCh(xferCh),
    .rdData(rdData), .xferAddr(xferAddr), .curAddr(curAddr), .baseAddr(baseAddr)
  );
endmodule

// File: rtl/dmaAddrRegsChk.sv
`timescale 1ns/1ps
module dmaAddrRegsChk
  import dmaAddrPkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          regCs,
  input logic                          regWr,
  input logic [CH_W-1:0]               regCh,
  input logic [DATA_W-1:0]             wrData,
  input logic [NUM_HALF-1:0]           clrPtr,
  input logic [NUM_HALF-1:0]           masterClr,
  input logic                          xferStb,
  input logic [CH_W-1:0]               xferCh,
  input logic [NUM_CH-1:0]             decMode,
  input logic [NUM_CH-1:0]             autoInit,
  input logic [NUM_CH-1:0]             termCnt,
  input logic [OUT_W-1:0]              xferAddr,
  input logic [NUM_HALF-1:0]           bytePtr,
  input logic [NUM_CH-1:0][ADDR_W-1:0] curAddr,
  input logic [NUM_CH-1:0][ADDR_W-1:0] baseAddr
);
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clrPtr[h] || masterClr[h]) |=> !bytePtr[h]); // R7
    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (regCs && regCh[CH_W-1] == 1'(h) && !clrPtr[h] && !masterClr[h])
        |=> bytePtr[h] != $past(bytePtr[h])); // R6
    AST_PTR_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (regCs && regCh[CH_W-1] != 1'(h) && !clrPtr[h] && !masterClr[h])
        |=> $stable(bytePtr[h])); // R6
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_WR_LO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (regCs && regWr && regCh == CH_W'(c) && !bytePtr[regCh[CH_W-1]])
        |=> (curAddr[c][DATA_W-1:0] == $past(wrData)) && (baseAddr[c][DATA_W-1:0] == $past(wrData))); // R1
    AST_WR_HI_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (regCs && regWr && regCh == CH_W'(c) && bytePtr[regCh[CH_W-1]])
        |=> (curAddr[c][ADDR_W-1:DATA_W] == $past(wrData)) && (baseAddr[c][ADDR_W-1:DATA_W] == $past(wrData))); // R1
    if (c == CASCADE_CH) begin : g_casc
      AST_CASCADE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xferStb && xferCh == CH_W'(c) && !(regCs && regWr && regCh == CH_W'(c)))
          |=> $stable(curAddr[c])); // R8
    end else begin : g_xfer
      AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xferStb && xferCh == CH_W'(c) && !(autoInit[c] && termCnt[c]) && !(regCs && regWr && regCh == CH_W'(c)))
          |=> curAddr[c] == ($past(decMode[c]) ? $past(curAddr[c]) - ADDR_W'(1) : $past(curAddr[c]) + ADDR_W'(1))); // R3
      AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (xferStb && xferCh == CH_W'(c) && autoInit[c] && termCnt[c] && !(regCs && regWr && regCh == CH_W'(c)))
          |=> curAddr[c] == $past(baseAddr[c])); // R4
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (xferStb && xferCh == CH_W'(c) && regCs && regWr && regCh == CH_W'(c))
          |=> curAddr[c] == baseAddr[c] || !$stable(baseAddr[c]) || $past(curAddr[c] != baseAddr[c])); // R9
    end
  end

  AST_WORD_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(xferCh) >= HALF_CH) |-> !xferAddr[0]); // R5
  AST_CASCADE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (xferCh == CH_W'(CASCADE_CH)) |-> xferAddr == '0); // R8
endmodule

bind dmaAddrRegs dmaAddrRegsChk i_chk (.*);

// File: tb/test_dmaAddrRegs.sv
`timescale 1ns/1ps
module test_dmaAddrRegs;
  import dmaAddrPkg::*;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                regCs = 1'b0, regWr = 1'b0;
  logic [CH_W-1:0]     regCh = '0;
  logic [DATA_W-1:0]   wrData = '0;
  logic [DATA_W-1:0]   rdData;
  logic [NUM_HALF-1:0] clrPtr = '0, masterClr = '0;
  logic                xferStb = 1'b0;
  logic [CH_W-1:0]     xferCh = '0;
  logic [NUM_CH-1:0]   decMode = '0, autoInit = '0, termCnt = '0;
  logic [OUT_W-1:0]    xferAddr;

  dmaAddrRegs i_dmaAddrRegs (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R10";

  // behavioural reference
  int mBase[NUM_CH];
  int mCur[NUM_CH];
  bit bKnLo[NUM_CH], bKnHi[NUM_CH], cKnLo[NUM_CH], cKnHi[NUM_CH];
  bit mPtr[NUM_HALF];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPtr[0] = 0; mPtr[1] = 0;
    end else begin
      int h, x;
      bit wrHit;
      h = int'(regCh) / HALF_CH;
      x = int'(xferCh);
      wrHit = regCs && regWr;
      if (wrHit) begin
        int c;
        c = int'(regCh);
        if (!mPtr[h]) begin
          mBase[c] = (mBase[c] & 'hFF00) | int'(wrData);
          mCur[c]  = (mCur[c] & 'hFF00) | int'(wrData);
          bKnLo[c] = 1; cKnLo[c] = 1;
        end else begin
          mBase[c] = (mBase[c] & 'h00FF) | (int'(wrData) << 8);
          mCur[c]  = (mCur[c] & 'h00FF) | (int'(wrData) << 8);
          bKnHi[c] = 1; cKnHi[c] = 1;
        end
      end
      if (xferStb && x != CASCADE_CH && !(wrHit && regCh == xferCh)) begin
        if (autoInit[x] && termCnt[x]) begin
          mCur[x] = mBase[x]; cKnLo[x] = bKnLo[x]; cKnHi[x] = bKnHi[x];
        end else begin
          bit k;
          mCur[x] = decMode[x] ? ((mCur[x] - 1) & 'hFFFF) : ((mCur[x] + 1) & 'hFFFF);
          k = cKnLo[x] && cKnHi[x];
          cKnLo[x] = k; cKnHi[x] = k;
        end
      end
      for (int hh = 0; hh < NUM_HALF; hh++) begin
        if (clrPtr[hh] || masterClr[hh]) mPtr[hh] = 0;
        else if (regCs && h == hh) mPtr[hh] = !mPtr[hh];
      end
    end
  end

  task automatic check(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  // compare outputs against the model away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (regCs && !regWr) begin
        int c, h;
        c = int'(regCh); h = c / HALF_CH;
        if (!mPtr[h] && cKnLo[c]) check({tag, " read low byte"}, int'(rdData), mCur[c] & 'hFF);
        if (mPtr[h] && cKnHi[c]) check({tag, " read high byte"}, int'(rdData), (mCur[c] >> 8) & 'hFF);
      end
      if (xferStb) begin
        int x;
        x = int'(xferCh);
        if (x == CASCADE_CH) check({tag, " R8 cascade address"}, int'(xferAddr), 0);
        else if (cKnLo[x] && cKnHi[x]) begin
          if (x >= HALF_CH) check({tag, " R5 word address"}, int'(xferAddr), mCur[x] << 1);
          else check({tag, " R5 byte address"}, int'(xferAddr), mCur[x]);
        end
      end
    end
  end

  task automatic idleAll();
    regCs = 0; regWr = 0; xferStb = 0; clrPtr = '0; masterClr = '0;
  endtask
  task automatic nextCyc();
    @(posedge clk); #1; idleAll();
  endtask
  task automatic doWr(int ch, int d);
    nextCyc(); regCs = 1; regWr = 1; regCh = CH_W'(ch); wrData = DATA_W'(d);
  endtask
  task automatic doRd(int ch);
    nextCyc(); regCs = 1; regWr = 0; regCh = CH_W'(ch);
  endtask
  task automatic doXfer(int ch);
    nextCyc(); xferStb = 1; xferCh = CH_W'(ch);
  endtask
  task automatic wr16(int ch, int v);
    doWr(ch, v & 'hFF); doWr(ch, (v >> 8) & 'hFF);
  endtask
  task automatic rd16(int ch);
    doRd(ch); doRd(ch);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    tag = "R10"; // pointer starts on low byte after reset
    wr16(0, 'h1234); rd16(0);

    tag = "R1";
    wr16(2, 'hFFFE); rd16(2);
    wr16(1, 'h0001); rd16(1);

    tag = "R3";
    decMode = 8'b0000_0010;
    doXfer(2); doXfer(2); doXfer(2); rd16(2);   // FFFE -> 0001 wrapping up
    doXfer(1); doXfer(1); doXfer(1); rd16(1);   // 0001 -> FFFE wrapping down

    tag = "R2"; // current moved away from base
    wr16(3, 'h4000); doXfer(3); doXfer(3); rd16(3);

    tag = "R4";
    autoInit = 8'b0000_1000;
    termCnt  = 8'b0000_1010;
    doXfer(3); rd16(3);          // reload to 4000
    doXfer(1); rd16(1);          // no auto-init: steps
    termCnt = '0;
    doXfer(3); rd16(3);

    tag = "R5";
    wr16(5, 'h8001); doXfer(5); rd16(5);
    decMode[6] = 1;
    wr16(6, 'hFFFF); doXfer(6); doXfer(6);
    wr16(7, 'h0000); doXfer(7);
    doXfer(0);

    tag = "R6"; // shared pointer within a half
    doWr(0, 'hAA); doRd(1);      // second access of half 0 lands on high byte
    doWr(5, 'h11); doRd(0);      // half 1 access leaves half 0 pointer
    doRd(0); doRd(5);
    rd16(6);

    tag = "R7";
    doWr(2, 'h55); nextCyc(); clrPtr = 2'b01; rd16(2);
    doRd(6); nextCyc(); masterClr = 2'b10; rd16(6);
    doWr(1, 'h77);
    nextCyc(); regCs = 1; regWr = 0; regCh = 3'd1; clrPtr = 2'b01; // read hi while clearing
    rd16(1);

    tag = "R8";
    wr16(4, 'h2345); doXfer(4); doXfer(4); rd16(4);

    tag = "R9";
    wr16(0, 'h0100);
    nextCyc(); regCs = 1; regWr = 1; regCh = 3'd0; wrData = 8'h20; xferStb = 1; xferCh = 3'd0;
    doRd(0); doRd(0);
    nextCyc(); regCs = 1; regWr = 1; regCh = 3'd7; wrData = 8'h09; xferStb = 1; xferCh = 3'd2;
    doRd(7); doXfer(2); rd16(2);

    tag = "R3 mixed";
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      nextCyc();
      decMode  = NUM_CH'($urandom);
      autoInit = NUM_CH'($urandom);
      termCnt  = NUM_CH'($urandom);
      if (op < 3) begin regCs = 1; regWr = 1; regCh = CH_W'($urandom); wrData = DATA_W'($urandom); end
      else if (op < 6) begin regCs = 1; regWr = 0; regCh = CH_W'($urandom); end
      if (op >= 2) begin xferStb = 1; xferCh = CH_W'($urandom); end
      if (op == 9) clrPtr = NUM_HALF'($urandom);
      if (op == 8) masterClr = NUM_HALF'($urandom);
    end
    nextCyc(); decMode = '0; autoInit = '0; termCnt = '0;
    nextCyc();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule